// File: doc/BRIEF.md
# Two-Channel Compare Match Interval Timer

This peripheral provides two independent interval channels. Each one has a 16-bit up-counter and a 16-bit constant register. The counter advances on a count clock that is divided down from the module clock. When the counter reaches the constant, the channel sets a sticky match flag. On the next count clock the counter wraps back to zero, so a channel with constant N produces a match every N+1 count clocks. A channel can raise a level-high interrupt request for as long as its flag is set.

Software reaches the block through a simple 16-bit register bus. There is one shared run/stop register, and each channel has its own control/status register, counter and constant. Read data is registered and appears on the cycle after the read. To clear a match flag, software must first read the control/status register while the flag is set and then write that register with the flag bit at 0. If a new match lands between the read and the write, the flag survives the write, so no event is lost.

Top module: `match_interval_timer`

## Requirements
- R1: After reset every register reads 0x0000, both channels are stopped and both interrupt lines are low.
- R2: The halfword byte offsets are: run/stop register 0x0, channel 0 control 0x2, counter 0x4, constant 0x6, channel 1 control 0x8, counter 0xA, constant 0xC. Bit 0 of the run/stop register runs channel 0 and bit 1 runs channel 1. Read data appears on `bus_rdata` one clock after the read cycle.
- R3: Control/status layout: bit 7 is the match flag, which the bus cannot set. Bit 6 is the interrupt enable and bits 1:0 are the clock select. Bits 15:8 and 5:2 read 0.
- R4: While a channel runs, its counter advances once every 8 << (2 × select) clocks (8, 32, 128 or 512). The first advance comes exactly that many clocks after the edge that wrote the run bit.
- R5: A stopped channel holds its counter value.
- R6: The flag sets on the same edge on which the counter becomes equal to the constant. On the following advance the counter becomes 0.
- R7: A channel's interrupt line is high exactly when its flag and its interrupt enable are both 1.
- R8: A control/status write with bit 7 at 0 clears the flag only if a read of that register saw the flag set and no control/status write came between. Writing bit 7 as 1 never changes the flag.
- R9: A match that occurs between the arming read and the clearing write cancels the clear, and the flag stays set.
- R10: A write to a counter or constant register takes effect on that clock edge and reads back at once.
- R11: The two channels are independent: running, matching or interrupting one leaves the other's counter and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset of the halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after a read |
| irq | output | 2 | Level-high interrupt request, one bit per channel |

## Verification
A read result is due one clock after its read cycle. The driver queues the expected word when it issues the read, and the monitor compares it at the falling edge after the capturing edge. Counter timing is made exact by bracketing a run between two writes to the run register spaced a known number of clocks apart: the stop-write edge still counts, so a window of 2 × divider clocks gives exactly two advances and a window one clock shorter gives one. Interrupt levels depend only on registered state, so they are checked at the falling edge after the write or stop that changed them.

// File: rtl/mit_pkg.sv
package mit_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 4;
  localparam int CKS_W      = 2;
  // register offsets (byte addresses of halfwords)
  localparam int OFF_RUN    = 0;
  localparam int CH_BASE    = 2;
  localparam int CH_STRIDE  = 6;
  localparam int OFF_CSR    = 0;
  localparam int OFF_CNT    = 2;
  localparam int OFF_COR    = 4;
  // control/status bit positions
  localparam int BIT_FLAG   = 7;
  localparam int BIT_IE     = 6;
  // prescaler: divide = 2**(BASE_LOG2 + STEP_LOG2*select)
  localparam int BASE_LOG2  = 3;
  localparam int STEP_LOG2  = 2;

  function automatic int ch_addr(int ch, int off);
    return CH_BASE + CH_STRIDE * ch + off;
  endfunction
endpackage

// File: rtl/mit_prescaler.sv
module mit_prescaler
  import mit_pkg::*;
#(
  parameter int SEL_W = CKS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pre_q, pre_d, mask;
  int unsigned      shamt;

  always_comb begin
    shamt = BASE_LOG2 + STEP_LOG2 * int'(sel);
    mask  = (PRE_W'(1) << shamt) - PRE_W'(1);
    tick  = run && ((pre_q & mask) == mask);
    pre_d = run ? pre_q + PRE_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/mit_channel.sv
module mit_channel
  import mit_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             csr_wr,
  input  logic             csr_rd,
  input  logic             cnt_wr,
  input  logic             cor_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cor,
  output logic             flag,
  output logic             ie,
  output logic [CKS_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cor_q, cor_d, cnt_adv;
  logic             flag_q, flag_d, ie_q, ie_d, armed_q, armed_d, match;
  logic [CKS_W-1:0] sel_q, sel_d;

  mit_prescaler #(.SEL_W(CKS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel_q), .tick(tick)
  );

  always_comb begin
    cnt_adv = (cnt_q == cor_q) ? '0 : cnt_q + CNT_W'(1);
    match   = tick && !cnt_wr && (cnt_adv == cor_q);

    cnt_d = cnt_q;
    if (cnt_wr)    cnt_d = wdata;
    else if (tick) cnt_d = cnt_adv;

    cor_d = cor_wr ? wdata : cor_q;
    ie_d  = csr_wr ? wdata[BIT_IE] : ie_q;
    sel_d = csr_wr ? wdata[CKS_W-1:0] : sel_q;

    flag_d = flag_q;
    if (match)                                 flag_d = 1'b1;
    else if (csr_wr && armed_q && !wdata[BIT_FLAG]) flag_d = 1'b0;

    armed_d = armed_q;
    if (match || csr_wr)       armed_d = 1'b0;
    else if (csr_rd && flag_q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cor_q   <= '0;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      armed_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      cor_q   <= cor_d;
      flag_q  <= flag_d;
      ie_q    <= ie_d;
      armed_q <= armed_d;
      sel_q   <= sel_d;
    end
  end

  assign cnt  = cnt_q;
  assign cor  = cor_q;
  assign flag = flag_q;
  assign ie   = ie_q;
  assign sel  = sel_q;
endmodule

// File: rtl/match_interval_timer.sv
module match_interval_timer
  import mit_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq
);
  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                     wr_cyc, rd_cyc, run_wr;
  logic [NCH-1:0]           run_q, run_d;
  logic [NCH-1:0]           ch_flag, ch_ie, ch_tick;
  logic [NCH-1:0][DATA_W-1:0] ch_cnt, ch_cor;
  logic [NCH-1:0][CKS_W-1:0]  ch_sel;
  logic [NCH-1:0]           csr_wr, csr_rd, cnt_wr, cor_wr;
  logic [DATA_W-1:0]        rdata_q, rdata_d, rd_mux;

  assign wr_cyc = bus_en && bus_we;
  assign rd_cyc = bus_en && !bus_we;
  assign run_wr = wr_cyc && (bus_addr == ADDR_W'(OFF_RUN));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(ch_addr(i, OFF_CSR));
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ch_addr(i, OFF_CNT));
    localparam logic [ADDR_W-1:0] A_COR = ADDR_W'(ch_addr(i, OFF_COR));

    assign csr_wr[i] = wr_cyc && (bus_addr == A_CSR);
    assign csr_rd[i] = rd_cyc && (bus_addr == A_CSR);
    assign cnt_wr[i] = wr_cyc && (bus_addr == A_CNT);
    assign cor_wr[i] = wr_cyc && (bus_addr == A_COR);

    mit_channel #(.CNT_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_int_n), .run(run_q[i]),
      .csr_wr(csr_wr[i]), .csr_rd(csr_rd[i]),
      .cnt_wr(cnt_wr[i]), .cor_wr(cor_wr[i]), .wdata(bus_wdata),
      .cnt(ch_cnt[i]), .cor(ch_cor[i]), .flag(ch_flag[i]),
      .ie(ch_ie[i]), .sel(ch_sel[i]), .tick(ch_tick[i])
    );

    assign irq[i] = ch_flag[i] & ch_ie[i];
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_RUN)) rd_mux = DATA_W'(run_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(ch_addr(i, OFF_CSR))) begin
        rd_mux                  = '0;
        rd_mux[BIT_FLAG]        = ch_flag[i];
        rd_mux[BIT_IE]          = ch_ie[i];
        rd_mux[CKS_W-1:0]       = ch_sel[i];
      end
      if (bus_addr == ADDR_W'(ch_addr(i, OFF_CNT))) rd_mux = ch_cnt[i];
      if (bus_addr == ADDR_W'(ch_addr(i, OFF_COR))) rd_mux = ch_cor[i];
    end
    rdata_d = rd_cyc ? rd_mux : rdata_q;
    run_d   = run_wr ? bus_wdata[NCH-1:0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q   <= '0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/match_interval_timer_chk.sv
module match_interval_timer_chk
  import mit_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_en,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [NCH-1:0]             irq,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0]             flag,
  input logic [NCH-1:0]             ie,
  input logic [NCH-1:0]             tick,
  input logic [NCH-1:0][DATA_W-1:0] cnt,
  input logic [NCH-1:0][DATA_W-1:0] cor
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic w_csr, w_cnt, w_cor;
    assign w_csr = bus_en && bus_we && (bus_addr == ADDR_W'(ch_addr(i, OFF_CSR)));
    assign w_cnt = bus_en && bus_we && (bus_addr == ADDR_W'(ch_addr(i, OFF_CNT)));
    assign w_cor = bus_en && bus_we && (bus_addr == ADDR_W'(ch_addr(i, OFF_COR)));

    // R5: a stopped channel keeps its count
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !w_cnt) |=> $stable(cnt[i]));

    // R6: an advance from the constant value wraps to zero
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && !w_cnt && cnt[i] == cor[i]) |=> (cnt[i] == '0));

    // R6: the flag rises only together with counter equal to constant
    p_flag_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> ((cnt[i] == cor[i]) || $past(w_cor)));

    // R8: the flag can only fall through a control/status write
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !w_csr) |=> flag[i]);

    // R7: a request needs the enable
    p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (ie[i] && flag[i]));
  end
endmodule

bind match_interval_timer match_interval_timer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .irq(irq), .run(run_q), .flag(ch_flag),
  .ie(ch_ie), .tick(ch_tick), .cnt(ch_cnt), .cor(ch_cor)
);

// File: tb/match_interval_timer_bench.sv
module match_interval_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  match_interval_timer u_match_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // monitor: a read seen at this falling edge was captured at the last rising edge
  always @(negedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      if (exp_q.size() == 0) begin
        fails++; checks++;
        $display("FAIL scoreboard: read with no expected entry, actual %h expected none", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic [1:0] e, input string t);
    @(negedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  // run channel(s) for exactly n edges: stop-write edge is the n-th
  task automatic run_for(input logic [1:0] m, input int n);
    wr(4'h0, {14'd0, m});
    idle(n - 1);
    wr(4'h0, 16'h0000);
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 / R2: reset values at every offset
    rd(4'h0, 16'h0000, "R1 run reg");
    rd(4'h2, 16'h0000, "R1 csr0");
    rd(4'h4, 16'h0000, "R1 cnt0");
    rd(4'h6, 16'h0000, "R1 cor0");
    rd(4'h8, 16'h0000, "R1 csr1");
    rd(4'hA, 16'h0000, "R1 cnt1");
    rd(4'hC, 16'h0000, "R1 cor1");
    chk_irq(2'b00, "R1 irq");

    // R3: only flag/ie/select read back, flag not settable
    wr(4'h2, 16'hFFFF);
    rd(4'h2, 16'h0043, "R3 csr layout");
    wr(4'h2, 16'h0040);

    // R10: immediate writes
    wr(4'h6, 16'hFFFF);
    wr(4'h4, 16'h1234);
    rd(4'h4, 16'h1234, "R10 cnt write");
    rd(4'h6, 16'hFFFF, "R10 cor write");

    // R4: one clock short of two periods gives one advance
    wr(4'h4, 16'h0000);
    run_for(2'b01, 15);
    rd(4'h4, 16'h0001, "R4 div8 short window");

    // R4: exactly two periods for each select
    for (int c = 0; c < 4; c++) begin
      wr(4'h2, 16'h0040 | 16'(c));
      wr(4'h4, 16'h0000);
      run_for(2'b01, 2 * (8 << (2 * c)));
      rd(4'h4, 16'h0002, $sformatf("R4 select %0d", c));
    end

    // R5: stopped counter holds
    idle(40);
    rd(4'h4, 16'h0002, "R5 hold while stopped");

    // R6: match sets flag as counter reaches constant
    wr(4'h2, 16'h0040);
    wr(4'h6, 16'h0002);
    wr(4'h4, 16'h0000);
    run_for(2'b01, 16);
    rd(4'h4, 16'h0002, "R6 counter at constant");
    rd(4'h2, 16'h00C0, "R6 flag set");        // arms the clear
    chk_irq(2'b01, "R7 irq with flag and enable");
    run_for(2'b01, 8);
    rd(4'h4, 16'h0000, "R6 wrap to zero");

    // R8: writing 1 to flag keeps it; read then write 0 clears
    wr(4'h2, 16'h00C0);
    rd(4'h2, 16'h00C0, "R8 write 1 no effect");
    wr(4'h2, 16'h0040);
    rd(4'h2, 16'h0040, "R8 read then write 0 clears");
    chk_irq(2'b00, "R7 irq drops with flag");

    // R8: write 0 without arming read does nothing
    wr(4'h4, 16'h0001);
    run_for(2'b01, 8);
    wr(4'h2, 16'h0040);
    rd(4'h2, 16'h00C0, "R8 clear without read ignored");

    // R9: match between arming read and clearing write
    wr(4'h4, 16'h0001);
    run_for(2'b01, 8);
    wr(4'h2, 16'h0040);
    rd(4'h2, 16'h00C0, "R9 flag survives");
    wr(4'h2, 16'h0040);
    rd(4'h2, 16'h0040, "R9 later clear works");

    // R7: enable gates the request
    wr(4'h2, 16'h0000);
    wr(4'h4, 16'h0001);
    run_for(2'b01, 8);
    chk_irq(2'b00, "R7 flag without enable");
    wr(4'h2, 16'h0040);
    chk_irq(2'b01, "R7 enable raises request");

    // R11: channel 1 alone
    wr(4'hC, 16'h0000);
    wr(4'h8, 16'h0040);
    run_for(2'b10, 8);
    chk_irq(2'b11, "R11 channel 1 request");
    rd(4'h4, 16'h0002, "R11 channel 0 counter untouched");
    rd(4'h8, 16'h00C0, "R11 channel 1 flag");
    rd(4'h2, 16'h00C0, "R11 channel 0 flag unchanged");

    // R2: run register bits read back
    wr(4'h0, 16'h0003);
    rd(4'h0, 16'h0003, "R2 run bits");
    wr(4'h0, 16'h0000);
    rd(4'h0, 16'h0000, "R2 run cleared");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: pending entries actual %0d expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule